// File: doc/BRIEF.md
# Snooping Write-Through Data Cache with Posted Write Queue

This block is a small direct-mapped data cache that sits between a 32-bit byte-addressed CPU and main memory. Each line holds one 32-bit word together with a tag and a valid flag. A load that hits returns the word in the same cycle and does not stall. A load that misses stalls the CPU while the word is fetched, and the fetched word replaces whatever line held that index.

Stores always write through to memory. Each store updates the indexed line, allocating it on a miss, and places its address and data in a posted write queue. The CPU continues as soon as the queue accepts the store. The queue drains to memory in the order the stores arrived. Before any memory read is issued, the queue is emptied, so a read can never overtake a pending store.

The cache also watches a snoop input that carries the addresses that other bus agents write. When such an address matches a valid line, that line is invalidated. If the matching address is the one a refill is fetching, the refilled word is not marked valid and the load fetches it again.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, and neither memory request is asserted. The first load of any address therefore misses.
- R2: Address bits 1:0 are ignored. Bits 4:2 select one of 8 lines and bits 31:5 form the tag. Two addresses that differ only in bits 1:0 reach the same word.
- R3: A load whose line is valid with an equal tag completes without stall. In the same cycle `cpu_rdata` carries the stored word and no memory read is requested.
- R4: A load miss stalls the CPU. It requests the word-aligned address (bits 1:0 zero) and holds that request until acknowledged. The returned word then replaces the indexed line, so an address 32 bytes away with the same index is evicted.
- R5: A store writes its word, its tag and a set valid flag into the indexed line, on a hit or a miss. A later load of that address hits and returns the stored word.
- R6: Every accepted store appears on the memory write port with its address and data, in acceptance order. The port holds its address and data steady until acknowledged.
- R7: The posted write queue holds 4 stores. Four stores with no acknowledge are accepted without stall. A fifth stalls until an entry drains.
- R8: On a load miss the queue is drained first. The memory read request is never asserted while a write is pending.
- R9: A snooped write whose word address matches a valid line clears that line. A later load then misses. A snoop with the same index but a different tag leaves the line valid.
- R10: A snooped write to the address being refilled stops the refilled word from becoming valid. The load fetches it again and returns the second fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load is not stalled |
| cpu_stall | output | 1 | CPU must hold its request |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_ack | input | 1 | Read data valid, completes the read |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Posted write pending |
| mem_wr_addr | output | 32 | Address of the oldest pending write |
| mem_wr_data | output | 32 | Data of the oldest pending write |
| mem_wr_ack | input | 1 | Memory accepts the oldest pending write |
| snp_valid | input | 1 | Another agent writes on the shared bus |
| snp_addr | input | 32 | Address of that foreign write |

## Verification
A wrongly set valid flag or a corrupted tag shows up on the next load of that index. The load completes with no stall and the wrong word, or it stalls and issues a read where none was due. Either shows in the cycle after the load is presented. A queue pointer or count error shows as missing, repeated or reordered addresses on the write port. It can also show as a stall at the wrong queue occupancy, visible by the time the queue next drains. A missed snoop invalidation stays hidden until that address is next loaded, so each snoop test is followed directly by a load of the snooped word.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WORD_W = ADDR_W - 2;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_DRAIN = 2'd1,
    MS_READ  = 2'd2
  } miss_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } post_ent_t;

  // byte address -> word address (the two low bits never take part)
  function automatic logic [WORD_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction

  // word address -> aligned byte address for the memory side
  function automatic logic [ADDR_W-1:0] byte_of(logic [WORD_W-1:0] w);
    return {w, 2'b00};
  endfunction
endpackage

// File: rtl/wtc_line_store.sv
module wtc_line_store
  import wtc_pkg::*;
#(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned TAG_W = WORD_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  look_idx,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic              snp_en,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_kill,
  output logic [LINES-1:0]  valid_o
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign look_hit  = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
  assign look_data = data_q[look_idx];
  assign snp_kill  = snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign valid_o   = valid_q;

  // per-line valid flag: a write in the same cycle overrides a snoop kill
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        valid_q[g] <= wr_valid;
      end else if (snp_kill && (snp_idx == IDX_W'(g))) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/wtc_post_queue.sv
module wtc_post_queue
  import wtc_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  post_ent_t        push_ent,
  input  logic             pop,
  output post_ent_t        head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  post_ent_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = slot_q[rd_ptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot_q[wr_ptr_q] <= push_ent;
  end
endmodule

// File: rtl/wtc_refill_ctrl.sv
module wtc_refill_ctrl
  import wtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  logic              wb_empty,
  input  logic              rd_ack,
  input  logic              snp_en,
  input  logic [WORD_W-1:0] snp_word,
  output miss_st_e          state,
  output logic              rd_req,
  output logic [WORD_W-1:0] miss_word,
  output logic              fill_en,
  output logic              fill_ok
);
  miss_st_e          st_q;
  logic [WORD_W-1:0] word_q;
  logic              poison_q;
  logic              snp_same;

  assign snp_same  = snp_en && (snp_word == word_q);
  assign state     = st_q;
  assign rd_req    = (st_q == MS_READ);
  assign miss_word = word_q;
  assign fill_en   = rd_req && rd_ack;
  assign fill_ok   = !poison_q && !snp_same;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= MS_IDLE;
      word_q   <= '0;
      poison_q <= 1'b0;
    end else begin
      case (st_q)
        MS_IDLE: if (start) begin
          st_q     <= MS_DRAIN;
          word_q   <= start_word;
          poison_q <= 1'b0;
        end
        MS_DRAIN: if (wb_empty) st_q <= MS_READ;
        MS_READ: begin
          if (snp_same) poison_q <= 1'b1;
          if (rd_ack)   st_q     <= MS_IDLE;
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wtc_pkg::*;
#(
  parameter int unsigned LINES    = 8,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned TAG_W = WORD_W - IDX_W,
  localparam int unsigned CNT_W = $clog2(WB_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  // decoded addresses
  logic [WORD_W-1:0] cpu_word, snp_word, miss_word;
  logic [IDX_W-1:0]  cpu_idx, snp_idx, line_wr_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag, line_wr_tag;

  assign cpu_word = word_of(cpu_addr);
  assign snp_word = word_of(snp_addr);
  assign cpu_idx  = cpu_word[IDX_W-1:0];
  assign cpu_tag  = cpu_word[WORD_W-1:IDX_W];
  assign snp_idx  = snp_word[IDX_W-1:0];
  assign snp_tag  = snp_word[WORD_W-1:IDX_W];

  // named internal events
  logic             hit, snp_kill, fill_en, fill_ok;
  logic             ld_access, st_access, idle, store_go, miss_start;
  logic             line_wr_en, line_wr_valid;
  logic [DATA_W-1:0] line_wr_data;
  logic [LINES-1:0] line_valid;
  logic             wb_empty, wb_full, wb_pop;
  logic [CNT_W-1:0] wb_count;
  post_ent_t        wb_head, wb_in;
  miss_st_e         mstate;

  assign ld_access  = cpu_req && !cpu_we;
  assign st_access  = cpu_req && cpu_we;
  assign idle       = (mstate == MS_IDLE);
  assign store_go   = st_access && idle && !wb_full;
  assign miss_start = ld_access && idle && !hit;
  assign cpu_stall  = (ld_access && !(idle && hit)) || (st_access && !store_go);

  assign line_wr_en    = store_go || fill_en;
  assign line_wr_idx   = fill_en ? miss_word[IDX_W-1:0] : cpu_idx;
  assign line_wr_tag   = fill_en ? miss_word[WORD_W-1:IDX_W] : cpu_tag;
  assign line_wr_data  = fill_en ? mem_rd_data : cpu_wdata;
  assign line_wr_valid = fill_en ? fill_ok : 1'b1;

  wtc_line_store #(.LINES(LINES)) i_lines (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_idx  (cpu_idx),
    .look_tag  (cpu_tag),
    .look_hit  (hit),
    .look_data (cpu_rdata),
    .wr_en     (line_wr_en),
    .wr_idx    (line_wr_idx),
    .wr_tag    (line_wr_tag),
    .wr_data   (line_wr_data),
    .wr_valid  (line_wr_valid),
    .snp_en    (snp_valid),
    .snp_idx   (snp_idx),
    .snp_tag   (snp_tag),
    .snp_kill  (snp_kill),
    .valid_o   (line_valid)
  );

  assign wb_in.addr = cpu_addr;
  assign wb_in.data = cpu_wdata;
  assign wb_pop     = mem_wr_ack && !wb_empty;

  wtc_post_queue #(.DEPTH(WB_DEPTH)) i_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (store_go),
    .push_ent (wb_in),
    .pop      (wb_pop),
    .head     (wb_head),
    .empty    (wb_empty),
    .full     (wb_full),
    .count    (wb_count)
  );

  assign mem_wr_req  = !wb_empty;
  assign mem_wr_addr = wb_head.addr;
  assign mem_wr_data = wb_head.data;

  wtc_refill_ctrl i_refill (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (miss_start),
    .start_word (cpu_word),
    .wb_empty   (wb_empty),
    .rd_ack     (mem_rd_ack),
    .snp_en     (snp_valid),
    .snp_word   (snp_word),
    .state      (mstate),
    .rd_req     (mem_rd_req),
    .miss_word  (miss_word),
    .fill_en    (fill_en),
    .fill_ok    (fill_ok)
  );

  assign mem_rd_addr = byte_of(miss_word);
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
  import wtc_pkg::*;
#(
  parameter int unsigned LINES    = 8,
  parameter int unsigned WB_DEPTH = 4,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned CNT_W = $clog2(WB_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_ack,
  input logic [CNT_W-1:0]  wb_count,
  input logic              snp_kill,
  input logic [IDX_W-1:0]  snp_idx,
  input logic              line_wr_en,
  input logic [IDX_W-1:0]  line_wr_idx,
  input logic [LINES-1:0]  line_valid
);
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (line_valid == '0));

  assert_hit_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !cpu_stall) |-> !mem_rd_req);

  assert_read_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

  assert_read_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));

  assert_write_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_stall) |-> (wb_count < CNT_W'(WB_DEPTH)));

  assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !mem_wr_req);

  assert_snoop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_kill && !(line_wr_en && (line_wr_idx == snp_idx))) |=>
      !line_valid[$past(snp_idx)]);
endmodule

bind wt_snoop_cache wtc_checker #(.LINES(LINES), .WB_DEPTH(WB_DEPTH)) i_wtc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_we      (cpu_we),
  .cpu_stall   (cpu_stall),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_ack  (mem_rd_ack),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_ack  (mem_wr_ack),
  .wb_count    (wb_count),
  .snp_kill    (snp_kill),
  .snp_idx     (snp_idx),
  .line_wr_en  (line_wr_en),
  .line_wr_idx (line_wr_idx),
  .line_valid  (line_valid)
);

// File: tb/test_wt_snoop_cache.sv
module test_wt_snoop_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;

  always #5 clk = ~clk;

  wt_snoop_cache i_wt_snoop_cache (.*);

  int checks = 0, errors = 0;
  int rd_acks = 0, overlap = 0, rd_wait = 0;
  bit wr_ack_en = 1'b1;
  logic [31:0] wlog_a [64];
  logic [31:0] wlog_d [64];
  int wlog_n = 0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one CPU access; returns data and number of stalled cycles
  task automatic access(bit we, logic [31:0] a, logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    stalls = 0;
    #1;
    while (cpu_stall) begin
      @(negedge clk); #1; stalls++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(logic [31:0] a);
    @(negedge clk); snp_valid = 1'b1; snp_addr = a;
    @(negedge clk); snp_valid = 1'b0;
  endtask

  // memory responder: reads answered on the 2nd negedge, writes logged on ack
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req && mem_wr_req) overlap++;
      if (mem_rd_req && !mem_rd_ack) begin
        if (rd_wait == 1) begin
          mem_rd_ack = 1'b1; mem_rd_data = mem_word(mem_rd_addr);
          rd_wait = 0; rd_acks++;
        end else rd_wait++;
      end else mem_rd_ack = 1'b0;
      if (wr_ack_en && mem_wr_req) begin
        mem_wr_ack = 1'b1;
        wlog_a[wlog_n] = mem_wr_addr; wlog_d[wlog_n] = mem_wr_data;
        wlog_n = (wlog_n + 1) % 64;
      end else mem_wr_ack = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    report();
  end

  typedef struct packed {
    logic        we;
    logic        miss;
    logic        from_mem;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 32'h0000_0040, 32'h0},         // R1 R4 cold miss
    '{1'b0, 1'b0, 1'b1, 32'h0000_0040, 32'h0},         // R3 hit
    '{1'b0, 1'b0, 1'b1, 32'h0000_0043, 32'h0},         // R2 offset ignored
    '{1'b0, 1'b1, 1'b1, 32'h0000_0060, 32'h0},         // R4 conflict
    '{1'b0, 1'b1, 1'b1, 32'h0000_0040, 32'h0},         // R4 evicted
    '{1'b1, 1'b0, 1'b0, 32'h0000_0084, 32'h1111_2222}, // R5 store miss
    '{1'b0, 1'b0, 1'b0, 32'h0000_0084, 32'h1111_2222}, // R5 hit on stored
    '{1'b1, 1'b0, 1'b0, 32'h0000_0040, 32'h3333_4444}, // R5 store hit
    '{1'b0, 1'b0, 1'b0, 32'h0000_0040, 32'h3333_4444}, // R5
    '{1'b0, 1'b1, 1'b1, 32'h0000_005C, 32'h0}          // R2 line 7
  };

  initial begin
    logic [31:0] rd;
    int st, base, r0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chk(!mem_rd_req && !mem_wr_req && !cpu_stall, "R1 idle after reset",
        {29'd0, mem_rd_req, mem_wr_req, cpu_stall}, 32'd0);

    base = wlog_n;
    for (int i = 0; i < NV; i++) begin
      access(VECS[i].we, VECS[i].addr, VECS[i].data, rd, st);
      if (VECS[i].we) begin
        chk(st == 0, "R6 store accepted without stall", st, 0);
      end else begin
        chk((st > 0) == VECS[i].miss, "R3/R4 hit-miss by table", st, VECS[i].miss);
        chk(rd == (VECS[i].from_mem ? mem_word(VECS[i].addr) : VECS[i].data),
            "R2/R3/R5 load data", rd,
            VECS[i].from_mem ? mem_word(VECS[i].addr) : VECS[i].data);
      end
    end
    repeat (3) @(negedge clk);
    chk(wlog_n == base + 2, "R6 store count", wlog_n, base + 2);
    chk(wlog_a[base] == 32'h84 && wlog_d[base] == 32'h1111_2222, "R6 first write", wlog_a[base], 32'h84);
    chk(wlog_a[base+1] == 32'h40 && wlog_d[base+1] == 32'h3333_4444, "R6 second write", wlog_a[base+1], 32'h40);

    // R7: four posted stores, fifth stalls until drain
    wr_ack_en = 1'b0;
    base = wlog_n;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 32'h100 + 32'(4*i), 32'hA000 + 32'(i), rd, st);
      chk(st == 0, "R7 store into free slot", st, 0);
    end
    fork
      access(1'b1, 32'h110, 32'hA004, rd, st);
      begin repeat (5) @(negedge clk); wr_ack_en = 1'b1; end
    join
    chk(st >= 4, "R7 fifth store stalls while full", st, 5);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 5; i++)
      chk(wlog_a[base+i] == 32'h100 + 32'(4*i) && wlog_d[base+i] == 32'hA000 + 32'(i),
          "R6 drain order", wlog_a[base+i], 32'h100 + 32'(4*i));

    // R8: load miss waits for the queue to empty
    wr_ack_en = 1'b0;
    access(1'b1, 32'h200, 32'hBEEF, rd, st);
    fork
      access(1'b0, 32'h340, 32'h0, rd, st);
      begin
        repeat (4) @(negedge clk);
        chk(!mem_rd_req, "R8 no read while write pending", mem_rd_req, 0);
        wr_ack_en = 1'b1;
      end
    join
    chk(rd == mem_word(32'h340), "R8 load data after drain", rd, mem_word(32'h340));
    chk(st >= 4, "R8 load stalled through drain", st, 4);

    // R9: snoop invalidation
    access(1'b0, 32'h44, 32'h0, rd, st);
    access(1'b0, 32'h44, 32'h0, rd, st);
    chk(st == 0, "R9 line filled", st, 0);
    snoop(32'h64);
    access(1'b0, 32'h44, 32'h0, rd, st);
    chk(st == 0 && rd == mem_word(32'h44), "R9 other tag keeps line", st, 0);
    snoop(32'h46);
    access(1'b0, 32'h44, 32'h0, rd, st);
    chk(st > 0, "R9 snooped line misses", st, 1);
    chk(rd == mem_word(32'h44), "R9 refetched data", rd, mem_word(32'h44));

    // R10: snoop of the word being refilled forces a second fetch
    r0 = rd_acks;
    fork
      access(1'b0, 32'h500, 32'h0, rd, st);
      begin
        do @(negedge clk); while (!mem_rd_req);
        snp_valid = 1'b1; snp_addr = 32'h500;
        @(negedge clk); snp_valid = 1'b0;
      end
    join
    chk(rd_acks - r0 == 2, "R10 second fetch", rd_acks - r0, 2);
    chk(rd == mem_word(32'h500), "R10 data", rd, mem_word(32'h500));
    access(1'b0, 32'h500, 32'h0, rd, st);
    chk(st == 0, "R10 line valid after clean refill", st, 0);

    chk(overlap == 0, "R8 read never overlapped a pending write", overlap, 0);
    report();
  end
endmodule